// File: doc/BRIEF.md
# Debug-Mode Entry and Exit Controller

This block sits beside a CPU pipeline and decides when the hart enters debug mode, where the program counter goes while it is there, and how it leaves. In normal operation it watches for three entry reasons: an external halt request, an ebreak instruction, and completion of one instruction while single-stepping. When entry is taken, the next-PC override points at the park-loop address, the debug status register is given the entry reason and the privilege level the hart had, and the resume PC is saved. None of the machine trap registers is written on entry.

While the hart is in debug mode, it runs the park-loop code, which is not part of this block. The controller forces machine privilege and tells the memory-protection logic to bypass its checks. It holds back interrupts and turns wfi into a no-op. It also routes exceptions. An ebreak inside debug mode sends the PC back to the park loop. Any other exception sends it to a separate exception vector. A resume request performs the return from debug mode: the PC is reloaded with the saved resume address and the saved privilege level is handed back.

Both vector addresses are parameters. All redirect and register-write pulses are registered, so they appear one clock after the event that caused them.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, dbg_mode_o, pc_load_o, dcsr_we_o and priv_we_o are all 0.
- R2: In normal mode, an accepted entry event makes dbg_mode_o, pc_load_o and dcsr_we_o equal to 1 on the next cycle. On that cycle, pc_next_o equals PARK_ADDR and dcsr_prv_o equals priv_i as sampled in the event cycle.
- R3: The entry cause on dcsr_cause_o is encoded as 1 for ebreak, 3 for halt request and 4 for single step. The priority is ebreak over halt over step. A step event is step_en_i and retire_i both high.
- R4: mtrap_we_o is high exactly when exc_i is high in normal mode. In that cycle no debug entry is taken. mtrap_we_o is never high on an entry or while in debug mode.
- R5: While in debug mode, eff_priv_o is 2'b11 and pmp_bypass_o is 1. Otherwise eff_priv_o follows priv_i and pmp_bypass_o is 0.
- R6: wfi_sleep_o equals wfi_i only when the hart is in normal mode and not single-stepping. Otherwise it is 0.
- R7: An ebreak in debug mode gives pc_load_o = 1 with pc_next_o = PARK_ADDR on the next cycle. The hart stays in debug mode and dcsr_we_o stays 0.
- R8: Any other exception in debug mode gives pc_load_o = 1 with pc_next_o = EXC_ADDR on the next cycle, and the hart stays in debug mode.
- R9: irq_take_o equals irq_pend_i only in normal mode when step_en_i is 0. Pending interrupts are held otherwise.
- R10: A resume request in debug mode clears dbg_mode_o on the next cycle. In that same cycle, pc_load_o = 1 with pc_next_o equal to pc_i captured at entry, priv_we_o = 1, and priv_wdata_o equal to the saved privilege.
- R11: In debug mode, the events rank ebreak above other exceptions, and other exceptions above a resume request.
- R12: halt_req_i, retire_i and step events in debug mode cause no redirect and no status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| halt_req_i | input | 1 | Halt request from the debug module |
| resume_req_i | input | 1 | Resume request (dret) |
| ebreak_i | input | 1 | An ebreak instruction executed this cycle |
| exc_i | input | 1 | Any other exception this cycle |
| step_en_i | input | 1 | Single-step mode enabled |
| retire_i | input | 1 | One instruction completed this cycle |
| irq_pend_i | input | 1 | An interrupt is pending |
| wfi_i | input | 1 | A wfi instruction is decoded |
| priv_i | input | 2 | Current privilege level |
| pc_i | input | XLEN | PC to resume at if entry happens now |
| dbg_mode_o | output | 1 | Hart is in debug mode |
| pc_load_o | output | 1 | Next-PC override valid |
| pc_next_o | output | XLEN | Next-PC override value |
| dcsr_we_o | output | 1 | Debug status update pulse |
| dcsr_cause_o | output | 3 | Entry cause for the debug status register |
| dcsr_prv_o | output | 2 | Privilege saved at entry |
| priv_we_o | output | 1 | Privilege restore pulse on exit |
| priv_wdata_o | output | 2 | Privilege to restore |
| eff_priv_o | output | 2 | Effective privilege level |
| pmp_bypass_o | output | 1 | Memory-protection checks bypassed |
| mtrap_we_o | output | 1 | Machine trap registers may be written |
| irq_take_o | output | 1 | Interrupt may be taken |
| wfi_sleep_o | output | 1 | wfi may put the hart to sleep |

## Verification
The hardest situation to reach is several events colliding in one cycle. Examples are an ebreak together with another exception inside debug mode, an exception together with a resume request, and a halt together with a step completion in normal mode. Independent random stimulus seldom lines these up with the hart in the right mode. The bench therefore first steers the hart into or out of debug mode with directed cycles. It then drives the colliding inputs in a single cycle, and follows this with a long random phase. That phase uses low event rates, so that debug sessions last many cycles, and it toggles step mode.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_EBREAK = 3'd1,
    CAUSE_HALT   = 3'd3,
    CAUSE_STEP   = 3'd4
  } dbg_cause_e;

  typedef enum logic [1:0] {
    DACT_NONE = 2'd0,
    DACT_PARK = 2'd1,
    DACT_EXC  = 2'd2,
    DACT_EXIT = 2'd3
  } dbg_act_e;

  localparam int unsigned PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'b11;

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_entry_sel.sv
module dbg_entry_sel
  import dbg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbg_i,
  input  logic       halt_i,
  input  logic       ebreak_i,
  input  logic       exc_i,
  input  logic       step_en_i,
  input  logic       retire_i,
  output logic       enter_o,
  output dbg_cause_e cause_o,
  output logic       trap_we_o
);
  logic step_hit;
  logic any_reason;

  always_comb begin
    step_hit   = step_en_i & retire_i;
    any_reason = ebreak_i | halt_i | step_hit;
    // a normal-mode exception owns the cycle and goes to the machine trap path
    trap_we_o  = exc_i & ~dbg_i;
    enter_o    = ~dbg_i & ~exc_i & any_reason;
    if (ebreak_i)      cause_o = CAUSE_EBREAK;
    else if (halt_i)   cause_o = CAUSE_HALT;
    else if (step_hit) cause_o = CAUSE_STEP;
    else               cause_o = CAUSE_NONE;
  end

  assert_trap_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_we_o |-> !enter_o);
  assert_halt_over_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && halt_i && !ebreak_i) |-> cause_o == CAUSE_HALT);
  assert_no_entry_in_dbg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_i |-> !enter_o);
endmodule

// File: rtl/dbg_session_sel.sv
module dbg_session_sel
  import dbg_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dbg_i,
  input  logic     ebreak_i,
  input  logic     exc_i,
  input  logic     resume_i,
  output dbg_act_e act_o
);
  always_comb begin
    act_o = DACT_NONE;
    if (dbg_i) begin
      if (ebreak_i)      act_o = DACT_PARK;
      else if (exc_i)    act_o = DACT_EXC;
      else if (resume_i) act_o = DACT_EXIT;
    end
  end

  assert_idle_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_i |-> act_o == DACT_NONE);
  assert_ebreak_rank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && ebreak_i) |-> act_o == DACT_PARK);
endmodule

// File: rtl/dbg_gate.sv
module dbg_gate
  import dbg_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_i,
  input  logic              step_en_i,
  input  logic              irq_pend_i,
  input  logic              wfi_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic [PRIV_W-1:0] eff_priv_o,
  output logic              pmp_bypass_o,
  output logic              irq_take_o,
  output logic              wfi_sleep_o
);
  logic free_run;

  always_comb begin
    free_run     = ~dbg_i & ~step_en_i;
    eff_priv_o   = dbg_i ? PRIV_MACHINE : priv_i;
    pmp_bypass_o = dbg_i;
    irq_take_o   = irq_pend_i & free_run;
    wfi_sleep_o  = wfi_i & free_run;
  end

  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i || step_en_i) |-> !irq_take_o);
  assert_wfi_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i || step_en_i) |-> !wfi_sleep_o);
  assert_machine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_i |-> (eff_priv_o == PRIV_MACHINE && pmp_bypass_o));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter logic [XLEN-1:0] PARK_ADDR = 32'hFFFF_F800,
  parameter logic [XLEN-1:0] EXC_ADDR  = 32'hFFFF_F808,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req_i,
  input  logic              resume_req_i,
  input  logic              ebreak_i,
  input  logic              exc_i,
  input  logic              step_en_i,
  input  logic              retire_i,
  input  logic              irq_pend_i,
  input  logic              wfi_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              dbg_mode_o,
  output logic              pc_load_o,
  output logic [XLEN-1:0]   pc_next_o,
  output logic              dcsr_we_o,
  output logic [2:0]        dcsr_cause_o,
  output logic [1:0]        dcsr_prv_o,
  output logic              priv_we_o,
  output logic [1:0]        priv_wdata_o,
  output logic [1:0]        eff_priv_o,
  output logic              pmp_bypass_o,
  output logic              mtrap_we_o,
  output logic              irq_take_o,
  output logic              wfi_sleep_o
);
  logic       rst_s_n;
  logic       enter;
  dbg_cause_e cause;
  dbg_act_e   act;

  // pulse registers: update every cycle
  logic dbg_q, dbg_d;
  logic pcload_q, pcload_d;
  logic dcsrwe_q, dcsrwe_d;
  logic privwe_q, privwe_d;
  // payload registers: written under explicit enables
  logic [XLEN-1:0]   pcnext_q, pcnext_d;
  logic              pcnext_en;
  logic [XLEN-1:0]   dpc_q;
  logic [2:0]        cause_q;
  logic [PRIV_W-1:0] prv_q;
  logic              save_en;

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dbg_entry_sel u_entry (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .dbg_i     (dbg_q),
    .halt_i    (halt_req_i),
    .ebreak_i  (ebreak_i),
    .exc_i     (exc_i),
    .step_en_i (step_en_i),
    .retire_i  (retire_i),
    .enter_o   (enter),
    .cause_o   (cause),
    .trap_we_o (mtrap_we_o)
  );

  dbg_session_sel u_session (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .dbg_i    (dbg_q),
    .ebreak_i (ebreak_i),
    .exc_i    (exc_i),
    .resume_i (resume_req_i),
    .act_o    (act)
  );

  dbg_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .dbg_i        (dbg_q),
    .step_en_i    (step_en_i),
    .irq_pend_i   (irq_pend_i),
    .wfi_i        (wfi_i),
    .priv_i       (priv_i),
    .eff_priv_o   (eff_priv_o),
    .pmp_bypass_o (pmp_bypass_o),
    .irq_take_o   (irq_take_o),
    .wfi_sleep_o  (wfi_sleep_o)
  );

  // next-state logic
  always_comb begin
    dbg_d     = dbg_q;
    pcload_d  = 1'b0;
    dcsrwe_d  = 1'b0;
    privwe_d  = 1'b0;
    pcnext_d  = pcnext_q;
    pcnext_en = 1'b0;
    save_en   = enter;
    if (enter) begin
      dbg_d     = 1'b1;
      pcload_d  = 1'b1;
      dcsrwe_d  = 1'b1;
      pcnext_d  = PARK_ADDR;
      pcnext_en = 1'b1;
    end
    unique case (act)
      DACT_PARK: begin
        pcload_d  = 1'b1;
        pcnext_d  = PARK_ADDR;
        pcnext_en = 1'b1;
      end
      DACT_EXC: begin
        pcload_d  = 1'b1;
        pcnext_d  = EXC_ADDR;
        pcnext_en = 1'b1;
      end
      DACT_EXIT: begin
        dbg_d     = 1'b0;
        pcload_d  = 1'b1;
        privwe_d  = 1'b1;
        pcnext_d  = dpc_q;
        pcnext_en = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dbg_q    <= 1'b0;
      pcload_q <= 1'b0;
      dcsrwe_q <= 1'b0;
      privwe_q <= 1'b0;
    end else begin
      dbg_q    <= dbg_d;
      pcload_q <= pcload_d;
      dcsrwe_q <= dcsrwe_d;
      privwe_q <= privwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pcnext_q <= '0;
    end else if (pcnext_en) begin
      pcnext_q <= pcnext_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dpc_q   <= '0;
      cause_q <= '0;
      prv_q   <= '0;
    end else if (save_en) begin
      dpc_q   <= pc_i;
      cause_q <= cause;
      prv_q   <= priv_i;
    end
  end

  assign dbg_mode_o   = dbg_q;
  assign pc_load_o    = pcload_q;
  assign pc_next_o    = pcnext_q;
  assign dcsr_we_o    = dcsrwe_q;
  assign dcsr_cause_o = cause_q;
  assign dcsr_prv_o   = prv_q;
  assign priv_we_o    = privwe_q;
  assign priv_wdata_o = prv_q;

  assert_entry_park_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!dbg_mode_o && !exc_i && (halt_req_i || ebreak_i))
      |=> (dbg_mode_o && pc_load_o && dcsr_we_o && pc_next_o == PARK_ADDR));
  assert_prv_copy_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!dbg_mode_o && !exc_i && halt_req_i) |=> dcsr_prv_o == $past(priv_i));
  assert_ebreak_park_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dbg_mode_o && ebreak_i)
      |=> (dbg_mode_o && pc_load_o && !dcsr_we_o && pc_next_o == PARK_ADDR));
  assert_exc_vector_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dbg_mode_o && exc_i && !ebreak_i)
      |=> (dbg_mode_o && pc_load_o && pc_next_o == EXC_ADDR));
  assert_exit_restore_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(dbg_mode_o) |-> (pc_load_o && priv_we_o));
  assert_no_mtrap_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    dbg_mode_o |-> !mtrap_we_o);
  assert_dcsr_only_on_entry_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    dcsr_we_o |-> $rose(dbg_mode_o));
endmodule

// File: tb/dbg_mode_ctrl_tb_top.sv
module dbg_mode_ctrl_tb_top;
  localparam logic [31:0] PARK = 32'hFFFF_F800;
  localparam logic [31:0] EXCV = 32'hFFFF_F808;

  logic clk = 1'b0;
  logic rst_n;
  logic halt_req, resume_req, ebreak, exc, step_en, retire, irq_pend, wfi;
  logic [1:0] priv;
  logic [31:0] pc;
  logic dbg_mode, pc_load, dcsr_we, priv_we, pmp_bypass, mtrap_we, irq_take, wfi_sleep;
  logic [31:0] pc_next;
  logic [2:0] dcsr_cause;
  logic [1:0] dcsr_prv, priv_wdata, eff_priv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic        m_dbg = 1'b0, m_pcload = 1'b0, m_dcsrwe = 1'b0, m_privwe = 1'b0;
  logic [31:0] m_pcnext = '0, m_dpc = '0;
  logic [2:0]  m_cause = '0;
  logic [1:0]  m_prv = '0;
  string       m_tag = "R1";
  logic        step_mode = 1'b0;

  always #10 clk = ~clk;

  dbg_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .resume_req_i(resume_req),
    .ebreak_i(ebreak), .exc_i(exc), .step_en_i(step_en), .retire_i(retire),
    .irq_pend_i(irq_pend), .wfi_i(wfi), .priv_i(priv), .pc_i(pc),
    .dbg_mode_o(dbg_mode), .pc_load_o(pc_load), .pc_next_o(pc_next),
    .dcsr_we_o(dcsr_we), .dcsr_cause_o(dcsr_cause), .dcsr_prv_o(dcsr_prv),
    .priv_we_o(priv_we), .priv_wdata_o(priv_wdata), .eff_priv_o(eff_priv),
    .pmp_bypass_o(pmp_bypass), .mtrap_we_o(mtrap_we), .irq_take_o(irq_take),
    .wfi_sleep_o(wfi_sleep)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_cause(input logic e, input logic h);
    if (e)      return 3'd1;
    else if (h) return 3'd3;
    else        return 3'd4;
  endfunction

  // one clock of stimulus plus checking against the model
  task automatic cyc(input logic h, r, e, x, se, rt, ip, wf,
                     input logic [1:0] pv, input logic [31:0] pcv);
    @(negedge clk);
    // registered outputs, result of the previous cycle
    chk({m_tag, " dbg_mode"}, {31'd0, dbg_mode}, {31'd0, m_dbg});
    chk({m_tag, " pc_load"},  {31'd0, pc_load},  {31'd0, m_pcload});
    if (m_pcload) chk({m_tag, " pc_next"}, pc_next, m_pcnext);
    chk({m_tag, " R12 dcsr_we"}, {31'd0, dcsr_we}, {31'd0, m_dcsrwe});
    if (m_dcsrwe) begin
      chk("R3 dcsr_cause", {29'd0, dcsr_cause}, {29'd0, m_cause});
      chk("R2 dcsr_prv",   {30'd0, dcsr_prv},   {30'd0, m_prv});
    end
    chk("R10 priv_we", {31'd0, priv_we}, {31'd0, m_privwe});
    if (m_privwe) chk("R10 priv_wdata", {30'd0, priv_wdata}, {30'd0, m_prv});
    // drive this cycle
    halt_req = h; resume_req = r; ebreak = e; exc = x; step_en = se;
    retire = rt; irq_pend = ip; wfi = wf; priv = pv; pc = pcv;
    #1;
    chk("R4 mtrap_we",   {31'd0, mtrap_we},   {31'd0, x & ~m_dbg});
    chk("R5 eff_priv",   {30'd0, eff_priv},   {30'd0, (m_dbg ? 2'b11 : pv)});
    chk("R5 pmp_bypass", {31'd0, pmp_bypass}, {31'd0, m_dbg});
    chk("R9 irq_take",   {31'd0, irq_take},   {31'd0, ip & ~m_dbg & ~se});
    chk("R6 wfi_sleep",  {31'd0, wfi_sleep},  {31'd0, wf & ~m_dbg & ~se});
    // model next state
    m_pcload = 1'b0; m_dcsrwe = 1'b0; m_privwe = 1'b0; m_tag = "R12";
    if (!m_dbg) begin
      m_tag = "R4";
      if (!x && (e || h || (se && rt))) begin
        m_dbg = 1'b1; m_pcload = 1'b1; m_dcsrwe = 1'b1; m_pcnext = PARK;
        m_cause = exp_cause(e, h); m_prv = pv; m_dpc = pcv; m_tag = "R2";
      end
    end else if (e) begin
      m_pcload = 1'b1; m_pcnext = PARK; m_tag = (x || r) ? "R11" : "R7";
    end else if (x) begin
      m_pcload = 1'b1; m_pcnext = EXCV; m_tag = r ? "R11" : "R8";
    end else if (r) begin
      m_dbg = 1'b0; m_pcload = 1'b1; m_pcnext = m_dpc; m_privwe = 1'b1; m_tag = "R10";
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,0,0, 2'b00, 32'h100);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    halt_req = 0; resume_req = 0; ebreak = 0; exc = 0; step_en = 0;
    retire = 0; irq_pend = 0; wfi = 0; priv = 2'b00; pc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dbg_mode", {31'd0, dbg_mode}, 32'd0);
    chk("R1 pc_load",  {31'd0, pc_load},  32'd0);
    chk("R1 dcsr_we",  {31'd0, dcsr_we},  32'd0);
    chk("R1 priv_we",  {31'd0, priv_we},  32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_tag = "R1";

    // R3: halt together with a step completion -> cause 3
    cyc(1,0,0,0,1,1,1,1, 2'b01, 32'h2000);
    // R12: halt and step while already in debug -> nothing
    cyc(1,0,0,0,1,1,1,1, 2'b01, 32'h2004);
    // R11: ebreak with exception and resume -> park
    cyc(0,1,1,1,0,0,1,1, 2'b00, 32'h2008);
    // R11: exception with resume -> exception vector
    cyc(0,1,0,1,0,0,0,0, 2'b00, 32'h200C);
    // R10: resume -> back to saved PC and privilege
    cyc(0,1,0,0,0,0,0,0, 2'b10, 32'h2010);
    idle(1);
    // R3: ebreak with halt -> cause 1
    cyc(1,0,1,0,0,0,0,0, 2'b00, 32'h3000);
    cyc(0,1,0,0,0,0,0,0, 2'b00, 32'h3004);
    idle(1);
    // R4: exception with halt in normal mode -> trap only, no entry
    cyc(1,0,1,1,0,0,0,0, 2'b11, 32'h4000);
    idle(1);
    // R3: step completion alone -> cause 4
    cyc(0,0,0,0,1,0,1,1, 2'b00, 32'h5000);
    cyc(0,0,0,0,1,1,1,1, 2'b01, 32'h5004);
    cyc(0,1,0,0,1,0,0,0, 2'b00, 32'h5008);
    idle(2);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic h, r, e, x, rt, ip, wf;
      if ($urandom_range(39, 0) == 0) step_mode = ~step_mode;
      h  = ($urandom_range(9, 0) == 0);
      r  = ($urandom_range(5, 0) == 0);
      e  = ($urandom_range(15, 0) == 0);
      x  = ($urandom_range(11, 0) == 0);
      rt = $urandom_range(1, 0) == 1;
      ip = $urandom_range(1, 0) == 1;
      wf = ($urandom_range(3, 0) == 0);
      cyc(h, r, e, x, step_mode, rt, ip, wf, 2'($urandom_range(3, 0)),
          $urandom() & 32'hFFFF_FFFC);
    end
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule